// File: doc/BRIEF.md
# Supply and Fault Supervisor

This block sits between the filtered analog comparators of a multi-channel heater switch controller and its per-channel output logic. It qualifies each comparator level over a programmable time measured in ticks of a shared prescaler. From the qualified levels it forms three global decisions for the channel drivers: turn every output off, turn every output on, or mask open-load detection. It also exports one level per fault source, so that a diagnostic register can collect them and OR them into a module-failure bit.

Each fault source follows its own rule.

- Supply undervoltage, supply overvoltage and overtemperature clear themselves once the condition goes away.
- A qualified load-dump level overrides every shutdown. The override ends only when the overvoltage comparator has stayed low for the full supply filter time.
- A qualified charge-pump undervoltage stays latched after the pump recovers, until the control-input decoder issues a fresh switch-on command.
- Battery undervoltage only raises a flag, and only in operating modes 2 to 6.

Top module: `supply_fault_sup`

## Requirements
- R1: With `uv_i` held high continuously, `uv_flag_o` and `force_off_o` rise no earlier than (SUP_TICKS-1)·TICK_DIV+1 clocks and no later than SUP_TICKS·TICK_DIV clocks after it rises.
- R2: `ov_i` qualifies over the same window as R1 and sets `ov_flag_o` and `force_off_o`. Both the undervoltage and the overvoltage shutdown clear on the first clock edge after their input falls.
- R3: With `ld_i` held high for LD_TICKS ticks, `force_on_o` rises one clock after qualification. While `force_on_o` is high, `force_off_o` stays low, even when other faults are qualified.
- R4: Once set, `force_on_o` stays high after `ld_i` falls. It clears one clock after `ov_i` has been low continuously for SUP_TICKS ticks.
- R5: Charge-pump undervoltage qualified over CP_TICKS ticks sets `cp_flag_o` and `force_off_o`. Both stay set after `cp_uv_i` falls, until `on_cmd_i` is high on a clock edge while the charge-pump qualifier is inactive. A new qualification wins over a simultaneous command.
- R6: `bat_flag_o` qualifies `bat_uv_i` over BAT_TICKS ticks, and only while `mode_i` (3-bit binary code) holds a value from 2 to 6. In any other mode the flag clears on the next edge and its counter restarts. The flag does not force outputs off.
- R7: `ot_flag_o` and `force_off_o` follow `ot_i` with one clock of latency in both directions.
- R8: `ol_mask_o` follows `ol_low_i` with one clock of latency.
- R9: A qualification input that drops for even one clock before expiry restarts its count from zero.
- R10: After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Operating mode code, 1 to 6 |
| on_cmd_i | input | 1 | Fresh switch-on command pulse from the control-input decoder |
| uv_i | input | 1 | Supply undervoltage comparator |
| ov_i | input | 1 | Supply overvoltage comparator |
| ld_i | input | 1 | Supply load-dump comparator |
| ol_low_i | input | 1 | Supply below the open-load enable level |
| bat_uv_i | input | 1 | Battery undervoltage comparator |
| cp_uv_i | input | 1 | Charge-pump undervoltage comparator |
| ot_i | input | 1 | Junction overtemperature comparator |
| force_off_o | output | 1 | Turn all outputs off |
| force_on_o | output | 1 | Turn all outputs on (load-dump override) |
| ol_mask_o | output | 1 | Suppress open-load detection |
| uv_flag_o | output | 1 | Supply undervoltage fault level |
| ov_flag_o | output | 1 | Supply overvoltage fault level |
| bat_flag_o | output | 1 | Battery undervoltage fault level |
| cp_flag_o | output | 1 | Latched charge-pump fault level |
| ot_flag_o | output | 1 | Overtemperature fault level |

## Verification
The qualified flags appear between (N-1)·TICK_DIV+1 and N·TICK_DIV clocks after their input rises, because the tick phase is not visible at the ports. The bench therefore samples once at (N-1)·TICK_DIV clocks, where the flag must still be low, and once after the latest possible edge, where it must be high. The load-dump state adds one register, so its set and release checks allow one more clock. Overtemperature, the open-load mask, the self-clearing releases and the charge-pump clear all take exactly one clock, and are checked at the first falling edge after the stimulus. Inputs are driven and outputs sampled on falling edges.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam logic [2:0] MODE_BAT_LO = 3'd2;
  localparam logic [2:0] MODE_BAT_HI = 3'd6;

  // qualifier slot order
  localparam int Q_UV  = 0;
  localparam int Q_OV  = 1;
  localparam int Q_LD  = 2;
  localparam int Q_CP  = 3;
  localparam int Q_BAT = 4;
  localparam int Q_OVN = 5;
  localparam int NQ    = 6;

  typedef struct packed {
    logic uv;
    logic ov;
    logic bat;
    logic cp;
    logic ot;
  } sfs_flags_t;
endpackage

// File: rtl/sfs_tick.sv
module sfs_tick #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == CW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/sfs_qual.sv
module sfs_qual #(
  parameter int LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic in_i,
  output logic q_o
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_o   <= 1'b0;
    end else if (!in_i) begin
      cnt_q <= '0;
      q_o   <= 1'b0;
    end else if (tick_i && !q_o) begin
      if (cnt_q == W'(LIMIT - 1)) q_o <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  p_drop_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_i |=> !q_o);
  p_rise_needs_input_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_o) |-> $past(in_i));
endmodule

// File: rtl/supply_fault_sup.sv
module supply_fault_sup
  import sfs_pkg::*;
#(
  parameter int TICK_DIV  = 4,
  parameter int SUP_TICKS = 1500,
  parameter int LD_TICKS  = 10,
  parameter int CP_TICKS  = 600,
  parameter int BAT_TICKS = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  input  logic       on_cmd_i,
  input  logic       uv_i,
  input  logic       ov_i,
  input  logic       ld_i,
  input  logic       ol_low_i,
  input  logic       bat_uv_i,
  input  logic       cp_uv_i,
  input  logic       ot_i,
  output logic       force_off_o,
  output logic       force_on_o,
  output logic       ol_mask_o,
  output logic       uv_flag_o,
  output logic       ov_flag_o,
  output logic       bat_flag_o,
  output logic       cp_flag_o,
  output logic       ot_flag_o
);
  localparam int LIM [NQ] = '{SUP_TICKS, SUP_TICKS, LD_TICKS, CP_TICKS, BAT_TICKS, SUP_TICKS};

  logic          tick;
  logic [NQ-1:0] qin, qual;
  logic          bat_mode_ok;
  logic          ld_act_q, cp_lat_q, ot_q, olm_q;
  sfs_flags_t    flags;

  sfs_tick #(.DIV(TICK_DIV)) u_tick (.clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

  assign bat_mode_ok = (mode_i >= MODE_BAT_LO) && (mode_i <= MODE_BAT_HI);

  assign qin[Q_UV]  = uv_i;
  assign qin[Q_OV]  = ov_i;
  assign qin[Q_LD]  = ld_i;
  assign qin[Q_CP]  = cp_uv_i;
  assign qin[Q_BAT] = bat_uv_i & bat_mode_ok;
  assign qin[Q_OVN] = ~ov_i;   // overvoltage-absent qualifier for load-dump release

  generate
    for (genvar g = 0; g < NQ; g++) begin : g_qual
      sfs_qual #(.LIMIT(LIM[g])) u_qual (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_i(tick),
        .in_i  (qin[g]),
        .q_o   (qual[g])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_act_q <= 1'b0;
      cp_lat_q <= 1'b0;
      ot_q     <= 1'b0;
      olm_q    <= 1'b0;
    end else begin
      if (qual[Q_LD]) ld_act_q <= 1'b1;
      else if (qual[Q_OVN]) ld_act_q <= 1'b0;
      if (qual[Q_CP]) cp_lat_q <= 1'b1;     // set wins over command
      else if (on_cmd_i) cp_lat_q <= 1'b0;
      ot_q  <= ot_i;
      olm_q <= ol_low_i;
    end
  end

  assign flags.uv  = qual[Q_UV];
  assign flags.ov  = qual[Q_OV];
  assign flags.bat = qual[Q_BAT];
  assign flags.cp  = cp_lat_q;
  assign flags.ot  = ot_q;

  assign force_on_o  = ld_act_q;
  assign force_off_o = !ld_act_q && (flags.uv || flags.ov || flags.cp || flags.ot);
  assign ol_mask_o   = olm_q;
  assign uv_flag_o   = flags.uv;
  assign ov_flag_o   = flags.ov;
  assign bat_flag_o  = flags.bat;
  assign cp_flag_o   = flags.cp;
  assign ot_flag_o   = flags.ot;

  p_on_needs_ld_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(force_on_o) |-> $past(ld_i));
  p_ld_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_on_o && $past(ov_i)) |=> force_on_o);
  p_cp_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_flag_o && !on_cmd_i) |=> cp_flag_o);
  p_bat_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((mode_i >= MODE_BAT_LO) && (mode_i <= MODE_BAT_HI)) |=> !bat_flag_o);
  p_ot_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ot_i && !ld_act_q && !$rose(ld_act_q)) |=> (force_off_o || force_on_o));
endmodule

// File: tb/supply_fault_sup_bench.sv
module supply_fault_sup_bench;
  localparam int DIV = 2, SUP = 8, LD = 3, CP = 5, BAT = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode = 3'd3;
  logic on_cmd = 0, uv = 0, ov = 0, ld = 0, ol_low = 0, bat_uv = 0, cp_uv = 0, ot = 0;
  logic f_off, f_on, olm, uvf, ovf, batf, cpf, otf;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  supply_fault_sup #(.TICK_DIV(DIV), .SUP_TICKS(SUP), .LD_TICKS(LD),
                     .CP_TICKS(CP), .BAT_TICKS(BAT)) u_supply_fault_sup (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .on_cmd_i(on_cmd),
    .uv_i(uv), .ov_i(ov), .ld_i(ld), .ol_low_i(ol_low), .bat_uv_i(bat_uv),
    .cp_uv_i(cp_uv), .ot_i(ot), .force_off_o(f_off), .force_on_o(f_on),
    .ol_mask_o(olm), .uv_flag_o(uvf), .ov_flag_o(ovf), .bat_flag_o(batf),
    .cp_flag_o(cpf), .ot_flag_o(otf));

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic t_reset_r10();
    chk("R10", "force_off", f_off, 0); chk("R10", "force_on", f_on, 0);
    chk("R10", "ol_mask", olm, 0);     chk("R10", "uv_flag", uvf, 0);
    chk("R10", "ov_flag", ovf, 0);     chk("R10", "bat_flag", batf, 0);
    chk("R10", "cp_flag", cpf, 0);     chk("R10", "ot_flag", otf, 0);
  endtask

  task automatic t_uv_r1();
    uv = 1; step((SUP - 1) * DIV);
    chk("R1", "uv early", uvf, 0); chk("R1", "off early", f_off, 0);
    step(DIV + 1);
    chk("R1", "uv qualified", uvf, 1); chk("R1", "off on uv", f_off, 1);
    uv = 0; step(1);
    chk("R2", "uv release", uvf, 0); chk("R2", "off release uv", f_off, 0);
  endtask

  task automatic t_glitch_r9();
    uv = 1; step((SUP - 1) * DIV);
    uv = 0; step(1);
    uv = 1; step((SUP - 1) * DIV);
    chk("R9", "restart after glitch", f_off, 0);
    step(DIV + 1);
    chk("R9", "qualified after restart", f_off, 1);
    uv = 0; step(2);
  endtask

  task automatic t_ov_r2();
    ov = 1; step((SUP - 1) * DIV);
    chk("R2", "ov early", ovf, 0);
    step(DIV + 1);
    chk("R2", "ov qualified", ovf, 1); chk("R2", "off on ov", f_off, 1);
    ov = 0; step(1);
    chk("R2", "ov release", ovf, 0); chk("R2", "off release ov", f_off, 0);
    step(SUP * DIV + 2);
  endtask

  task automatic t_ld_r3_r4();
    ov = 1; ld = 1; step(LD * DIV + 2);
    chk("R3", "force_on set", f_on, 1);
    step(SUP * DIV);
    chk("R3", "ov flagged under override", ovf, 1);
    chk("R3", "off suppressed", f_off, 0);
    ld = 0; step(SUP * DIV + 4);
    chk("R4", "hold after ld drop", f_on, 1);
    ov = 0; step(1);
    chk("R2", "ov flag clears", ovf, 0);
    step((SUP - 1) * DIV - 1);
    chk("R4", "hold before ov-clear window", f_on, 1);
    step(DIV + 2);
    chk("R4", "release", f_on, 0);
  endtask

  task automatic t_cp_r5();
    cp_uv = 1; step((CP - 1) * DIV);
    chk("R5", "cp early", cpf, 0);
    step(DIV + 1);
    chk("R5", "cp latched", cpf, 1); chk("R5", "off on cp", f_off, 1);
    on_cmd = 1; step(1); on_cmd = 0;
    chk("R5", "set wins over cmd", cpf, 1);
    cp_uv = 0; step(10);
    chk("R5", "stays latched", cpf, 1); chk("R5", "off stays", f_off, 1);
    on_cmd = 1; step(1); on_cmd = 0;
    chk("R5", "cleared by cmd", cpf, 0); chk("R5", "off cleared", f_off, 0);
  endtask

  task automatic t_bat_r6();
    mode = 3'd1; bat_uv = 1; step(BAT * DIV + 4);
    chk("R6", "ignored in mode 1", batf, 0);
    mode = 3'd4; step((BAT - 1) * DIV);
    chk("R6", "bat early", batf, 0);
    step(DIV + 1);
    chk("R6", "bat flagged mode 4", batf, 1); chk("R6", "no shutdown", f_off, 0);
    mode = 3'd1; step(1);
    chk("R6", "clears leaving modes 2-6", batf, 0);
    bat_uv = 0; mode = 3'd3; step(2);
  endtask

  task automatic t_ot_ol_r7_r8();
    ot = 1; step(1);
    chk("R7", "ot flag", otf, 1); chk("R7", "off on ot", f_off, 1);
    ot = 0; step(1);
    chk("R7", "ot release", otf, 0); chk("R7", "off release ot", f_off, 0);
    ol_low = 1; step(1);
    chk("R8", "mask set", olm, 1);
    ol_low = 0; step(1);
    chk("R8", "mask clear", olm, 0);
  endtask

  initial begin
    step(3); rst_n = 1; step(1);
    t_reset_r10();
    t_uv_r1();
    t_glitch_r9();
    t_ov_r2();
    t_ld_r3_r4();
    t_cp_r5();
    t_bat_r6();
    t_ot_ol_r7_r8();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all-requirements actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule